// File: doc/BRIEF.md
# Pulse-Width Field Write Modulator

This block drives the single field-enable line of a low-frequency reader when a tag is being programmed. A start pulse causes it to power the tag by switching the field on for a charge interval. It then sends a 112-bit write frame. Each bit occupies a fixed period. The period opens with a field-off gap whose length carries the bit value, and the field is on for the remainder of the period. After the last bit the field stays on for a programming interval. The block then drops the field and raises a one-cycle done pulse.

The frame contents are sent in this order: a fixed keyword byte 0xBB, a fixed password byte 0xEB, eight payload bytes, two checksum bytes, and a closing write-frame word. Every byte goes out least significant bit first. The payload and checksum are captured from the input ports in the cycle the start is accepted. The checksum itself is supplied by the caller and is not computed here. All durations are whole numbers of a base unit, and one parameter sets how many clock cycles make up that unit (100 µs in the intended setting).

Top module: `pwfw_writer`

## Requirements
- R1: After reset `field_on_o`, `busy_o` and `done_o` are all low.
- R2: A start accepted at a clock edge makes `field_on_o` high from that edge on, and it stays high for exactly CHARGE_UNITS×TICKS_PER_UNIT cycles.
- R3: A frame bit of value 1 is sent as ONE_GAP_UNITS×TICKS_PER_UNIT cycles with the field low, followed by (BIT_UNITS−ONE_GAP_UNITS)×TICKS_PER_UNIT cycles with the field high (defaults 10 and 20 units: 1 ms off, 1 ms on).
- R4: A frame bit of value 0 is sent as ZERO_GAP_UNITS×TICKS_PER_UNIT cycles with the field low, followed by (BIT_UNITS−ZERO_GAP_UNITS)×TICKS_PER_UNIT cycles with the field high (default 3 units: 0.3 ms off, 1.7 ms on).
- R5: The 14 frame bytes are sent in this order: 0xBB, 0xEB, `data_i[7:0]` through `data_i[63:56]` in ascending byte order, `crc_i[7:0]`, `crc_i[15:8]`, 0x00, 0x03.
- R6: Within each byte, bit 0 is sent first and bit 7 last.
- R7: After the on-portion of the 112th bit, the field stays high for a further PROG_UNITS×TICKS_PER_UNIT cycles (default 150 units, 15 ms).
- R8: When the programming interval ends, `field_on_o` falls and `done_o` is high for exactly one cycle in the same cycle. While the block is idle, `field_on_o` stays low.
- R9: A start that arrives while `busy_o` is high is ignored. Payload and checksum are taken only at the accepted start, so later changes on `data_i` and `crc_i` do not alter the frame.
- R10: `busy_o` rises at the accepting edge, stays high through the whole sequence, and falls in the same cycle as the `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only while idle |
| data_i | input | 64 | Payload, byte 0 in bits 7:0 |
| crc_i | input | 16 | Checksum to transmit, low byte first |
| field_on_o | output | 1 | High when the reader field is on |
| busy_o | output | 1 | High while a write sequence runs |
| done_o | output | 1 | One-cycle pulse when the sequence ends |

## Verification
Every output is registered, so the field rises one edge after start is sampled. Every later transition lands exactly on a multiple of TICKS_PER_UNIT cycles counted from that edge. The bench drives inputs on the falling edge. It measures each high and low run of the field output by counting falling-edge samples, and compares each run against the unit arithmetic for the bit it expects from its own frame vector. The `done_o` and `busy_o` checks are taken at the first sample that shows the field low after the programming interval, and again one sample later.

// File: rtl/pwfw_pkg.sv
package pwfw_pkg;

  localparam int unsigned FRAME_BYTES = 14;
  localparam int unsigned FRAME_BITS  = FRAME_BYTES * 8;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CHARGE,
    PH_BITS,
    PH_PROG
  } pwfw_phase_e;

  // Byte at position idx of the write frame.
  function automatic logic [7:0] frame_byte(input logic [3:0] idx,
                                            input logic [63:0] data,
                                            input logic [15:0] crc);
    logic [7:0] b;
    case (idx)
      4'd0:    b = 8'hBB;
      4'd1:    b = 8'hEB;
      4'd2:    b = data[7:0];
      4'd3:    b = data[15:8];
      4'd4:    b = data[23:16];
      4'd5:    b = data[31:24];
      4'd6:    b = data[39:32];
      4'd7:    b = data[47:40];
      4'd8:    b = data[55:48];
      4'd9:    b = data[63:56];
      4'd10:   b = crc[7:0];
      4'd11:   b = crc[15:8];
      4'd12:   b = 8'h00;
      4'd13:   b = 8'h03;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/pwfw_tick.sv
module pwfw_tick #(
  parameter int unsigned TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic unit_stb
);
  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] tick_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
    end else if (clear) begin
      tick_cnt <= '0;
    end else if (run) begin
      if (tick_cnt == LAST) tick_cnt <= '0;
      else                  tick_cnt <= tick_cnt + 1'b1;
    end
  end

  assign unit_stb = run && (tick_cnt == LAST);

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tick_cnt <= LAST); // R2

  AST_TICK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (tick_cnt == '0)); // R2

endmodule

// File: rtl/pwfw_frame_sel.sv
module pwfw_frame_sel
  import pwfw_pkg::*;
#(
  parameter int unsigned IDX_W = $clog2(FRAME_BITS)
) (
  input  logic [63:0]      data,
  input  logic [15:0]      crc,
  input  logic [IDX_W-1:0] bit_idx,
  output logic             bit_val,
  output logic             last_bit
);
  logic [3:0] byte_idx;
  logic [2:0] bit_pos;
  logic [7:0] cur_byte;

  assign byte_idx = bit_idx[IDX_W-1:3];
  assign bit_pos  = bit_idx[2:0];

  always_comb begin
    cur_byte = frame_byte(byte_idx, data, crc);
    bit_val  = cur_byte[bit_pos];
  end

  assign last_bit = (bit_idx == IDX_W'(FRAME_BITS - 1));

endmodule

// File: rtl/pwfw_seq.sv
module pwfw_seq
  import pwfw_pkg::*;
#(
  parameter int unsigned CHARGE_UNITS   = 500,
  parameter int unsigned BIT_UNITS      = 20,
  parameter int unsigned ONE_GAP_UNITS  = 10,
  parameter int unsigned ZERO_GAP_UNITS = 3,
  parameter int unsigned PROG_UNITS     = 150,
  parameter int unsigned IDX_W          = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             unit_stb,
  input  logic             bit_val,
  input  logic             last_bit,
  output logic [IDX_W-1:0] bit_idx,
  output logic             field_on_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned MAXU   = max3(CHARGE_UNITS, BIT_UNITS, PROG_UNITS);
  localparam int unsigned UNIT_W = $clog2(MAXU + 1);
  localparam logic [UNIT_W-1:0] CH_LAST   = UNIT_W'(CHARGE_UNITS - 1);
  localparam logic [UNIT_W-1:0] BIT_LAST  = UNIT_W'(BIT_UNITS - 1);
  localparam logic [UNIT_W-1:0] PROG_LAST = UNIT_W'(PROG_UNITS - 1);
  localparam logic [UNIT_W-1:0] GAP_ONE   = UNIT_W'(ONE_GAP_UNITS);
  localparam logic [UNIT_W-1:0] GAP_ZERO  = UNIT_W'(ZERO_GAP_UNITS);

  pwfw_phase_e       phase;
  logic [UNIT_W-1:0] unit_cnt;
  logic [UNIT_W-1:0] gap_cur;
  logic [UNIT_W-1:0] unit_nxt;

  assign gap_cur  = bit_val ? GAP_ONE : GAP_ZERO;
  assign unit_nxt = unit_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      unit_cnt   <= '0;
      bit_idx    <= '0;
      field_on_o <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase      <= PH_CHARGE;
            unit_cnt   <= '0;
            bit_idx    <= '0;
            field_on_o <= 1'b1;
            busy_o     <= 1'b1;
          end
        end
        PH_CHARGE: begin
          if (unit_stb) begin
            if (unit_cnt == CH_LAST) begin
              phase      <= PH_BITS;
              unit_cnt   <= '0;
              field_on_o <= 1'b0;
            end else begin
              unit_cnt <= unit_nxt;
            end
          end
        end
        PH_BITS: begin
          if (unit_stb) begin
            if (unit_cnt == BIT_LAST) begin
              unit_cnt <= '0;
              if (last_bit) begin
                phase      <= PH_PROG;
                field_on_o <= 1'b1;
              end else begin
                bit_idx    <= bit_idx + 1'b1;
                field_on_o <= 1'b0;
              end
            end else begin
              unit_cnt <= unit_nxt;
              if (unit_nxt == gap_cur) field_on_o <= 1'b1;
            end
          end
        end
        PH_PROG: begin
          if (unit_stb) begin
            if (unit_cnt == PROG_LAST) begin
              phase      <= PH_IDLE;
              unit_cnt   <= '0;
              field_on_o <= 1'b0;
              busy_o     <= 1'b0;
              done_o     <= 1'b1;
            end else begin
              unit_cnt <= unit_nxt;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_IDLE_FIELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !field_on_o); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_BUSY_FALLS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R10

  AST_ACCEPT_RAISES_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy_o && field_on_o)); // R2

  AST_GAP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BITS) |-> (field_on_o == (unit_cnt >= gap_cur))); // R3

  AST_PROG_FIELD_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PROG) |-> field_on_o); // R7

endmodule

// File: rtl/pwfw_writer.sv
module pwfw_writer
  import pwfw_pkg::*;
#(
  parameter int unsigned TICKS_PER_UNIT = 100,
  parameter int unsigned CHARGE_UNITS   = 500,
  parameter int unsigned BIT_UNITS      = 20,
  parameter int unsigned ONE_GAP_UNITS  = 10,
  parameter int unsigned ZERO_GAP_UNITS = 3,
  parameter int unsigned PROG_UNITS     = 150
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [63:0] data_i,
  input  logic [15:0] crc_i,
  output logic        field_on_o,
  output logic        busy_o,
  output logic        done_o
);
  localparam int unsigned IDX_W = $clog2(FRAME_BITS);

  logic             accept;
  logic             unit_stb;
  logic             bit_val;
  logic             last_bit;
  logic [IDX_W-1:0] bit_idx;
  logic [63:0]      data_q;
  logic [15:0]      crc_q;

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      crc_q  <= '0;
    end else if (accept) begin
      data_q <= data_i;
      crc_q  <= crc_i;
    end
  end

  pwfw_tick #(.TICKS(TICKS_PER_UNIT)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .run      (busy_o),
    .unit_stb (unit_stb)
  );

  pwfw_frame_sel #(.IDX_W(IDX_W)) u_sel (
    .data     (data_q),
    .crc      (crc_q),
    .bit_idx  (bit_idx),
    .bit_val  (bit_val),
    .last_bit (last_bit)
  );

  pwfw_seq #(
    .CHARGE_UNITS   (CHARGE_UNITS),
    .BIT_UNITS      (BIT_UNITS),
    .ONE_GAP_UNITS  (ONE_GAP_UNITS),
    .ZERO_GAP_UNITS (ZERO_GAP_UNITS),
    .PROG_UNITS     (PROG_UNITS),
    .IDX_W          (IDX_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .unit_stb   (unit_stb),
    .bit_val    (bit_val),
    .last_bit   (last_bit),
    .bit_idx    (bit_idx),
    .field_on_o (field_on_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(data_q) && $stable(crc_q))); // R9

endmodule

// File: tb/pwfw_writer_test.sv
module pwfw_writer_test;
  localparam int T  = 2;
  localparam int CH = 500;
  localparam int BU = 20;
  localparam int G1 = 10;
  localparam int G0 = 3;
  localparam int PU = 150;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] data_i = '0;
  logic [15:0] crc_i = '0;
  logic        field_on_o, busy_o, done_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pwfw_writer #(
    .TICKS_PER_UNIT(T), .CHARGE_UNITS(CH), .BIT_UNITS(BU),
    .ONE_GAP_UNITS(G1), .ZERO_GAP_UNITS(G0), .PROG_UNITS(PU)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
    .crc_i(crc_i), .field_on_o(field_on_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [63:0] d, input logic [15:0] c, input bit poke);
    logic [111:0] fr;
    int n, lo, hi, g, exp_hi, busy_lo;
    fr = {8'h03, 8'h00, c, d, 8'hEB, 8'hBB};
    busy_lo = 0;
    @(negedge clk);
    data_i = d; crc_i = c; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R10", "busy after accept", int'(busy_o), 1);
    n = 0;
    while (field_on_o && n < 100000) begin
      if (poke && n == 20) begin start_i = 1'b1; data_i = ~d; crc_i = ~c; end
      if (poke && n == 21) start_i = 1'b0;
      if (!busy_o) busy_lo++;
      n++;
      @(negedge clk);
    end
    chk("R2", "charge cycles", n, CH * T);
    for (int k = 0; k < 112; k++) begin
      g = fr[k] ? G1 : G0;
      lo = 0;
      while (!field_on_o && lo < 1000) begin
        if (!busy_o) busy_lo++;
        lo++;
        @(negedge clk);
      end
      chk(fr[k] ? "R3 R5 R6 (R9)" : "R4 R5 R6 (R9)", $sformatf("bit %0d gap", k), lo, g * T);
      hi = 0;
      while (field_on_o && hi < 100000) begin
        if (!busy_o) busy_lo++;
        hi++;
        @(negedge clk);
      end
      exp_hi = (BU - g) * T + ((k == 111) ? PU * T : 0);
      chk((k == 111) ? "R7" : (fr[k] ? "R3" : "R4"), $sformatf("bit %0d on time", k), hi, exp_hi);
    end
    chk("R8", "done at field drop", int'(done_o), 1);
    chk("R10", "busy low at done", int'(busy_o), 0);
    chk("R10", "busy dropouts during run", busy_lo, 0);
    @(negedge clk);
    chk("R8", "done one cycle", int'(done_o), 0);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      if (field_on_o || busy_o) n++;
      @(negedge clk);
    end
    chk("R8", "idle field low", n, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "field at reset", int'(field_on_o), 0);
    chk("R1", "busy at reset", int'(busy_o), 0);
    chk("R1", "done at reset", int'(done_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "field after reset", int'(field_on_o), 0);
    run_frame(64'h0, 16'h0000, 1'b0);
    run_frame(64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 1'b0);
    run_frame(64'h0123_4567_89AB_CDEF, 16'hA55A, 1'b1);
    run_frame(64'h8000_0000_0000_0001, 16'h8001, 1'b1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule